// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Detection

This block compares two divided pulse trains inside a frequency synthesizer: a reference strobe, taken from the reference divider, and a feedback strobe, taken from the VCO divider. Both strobes are single-cycle pulses that are synchronous to the reference-oscillator clock. Whichever strobe arrives first raises its pump output. When the other strobe arrives, both outputs stay high together for a short fixed overlap and are then cleared. This overlap removes the dead zone around zero phase error.

The phase error of each comparison is measured in oscillator clock periods and feeds a lock detector. The detector drops the lock flag at once on a large error. It raises the flag only after a run of small-error comparisons. Further controls act on the outputs:
- A polarity input swaps the two comparator outputs and reverses the charge-pump direction.
- An active-low hold input forces the charge pump to high impedance.
- An active-low power-save input idles the comparator and forces the lock flag high. When power-save is released, the comparator throws away the first strobe pair, because the phase relationship is unknown at that point.

A monitor pin carries either the lock flag or the selected divided strobe. A current-select bit passes straight through to the analog pump.

Top module: `pfd_lock_top`

## Requirements
- R1: A reference strobe that arrives with no feedback strobe pending sets the up state at that clock edge. A feedback strobe that arrives first sets the down state. The state stays set until the other strobe arrives. A repeated strobe of the leading kind has no effect.
- R2: When the second strobe of a pair arrives, or both arrive on the same edge, up and down are both high for OVL_CYC cycles (default 1) and are then both cleared. Strobes that arrive while both are high are dropped.
- R3: With pol_i=1, ref_pulse_o carries up, fb_pulse_o carries down, and cp_src_o=1 means source current while up is active. With pol_i=0, the two pulse outputs swap and cp_src_o=1 marks down.
- R4: cp_en_o is high only while exactly one of up and down is active and hold_ni is high. With hold_ni=0 the pump is at high impedance (cp_en_o=0).
- R5: The phase error of a comparison is the number of clock edges from the first strobe to the second strobe. Coincident strobes give 0. The value saturates at ERR_SAT (default 5).
- R6: A comparison whose error is at least UNLOCK_TH (default 2) clears lock_o on the edge that ends the comparison.
- R7: A comparison whose error is at most LOCK_TH (default 4) extends a streak, and any larger error resets the streak to 0. lock_o rises at the end of a comparison once the streak has reached LOCK_CNT (default 3) and that comparison's error is below UNLOCK_TH.
- R8: While ps_ni=0, lock_o=1, both pulse outputs and cp_en_o are 0, strobes are ignored, and the streak and the stored lock are cleared.
- R9: After reset and after power-save is released, the comparator waits for at least one reference strobe and one feedback strobe. That first pair raises no pulse output and does not update lock.
- R10: mon_o equals lock_o when mon_sel_i=0. When mon_sel_i=1, it equals ref_stb_i if pol_i=1 and fb_stb_i if pol_i=0.
- R11: cs_o always equals cs_i.
- R12: After reset (with ps_ni=1), all pulse outputs, cp_en_o and lock_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_stb_i | input | 1 | Divided reference strobe, one cycle |
| fb_stb_i | input | 1 | Divided feedback strobe, one cycle |
| pol_i | input | 1 | Output polarity select |
| mon_sel_i | input | 1 | Monitor source: 1 strobe, 0 lock flag |
| hold_ni | input | 1 | Low forces charge pump to high impedance |
| ps_ni | input | 1 | Low selects power-save |
| cs_i | input | 1 | Charge-pump current select |
| ref_pulse_o | output | 1 | Comparator output, reference side after polarity |
| fb_pulse_o | output | 1 | Comparator output, feedback side after polarity |
| cp_en_o | output | 1 | Charge pump driving (0 = high impedance) |
| cp_src_o | output | 1 | Charge pump direction, 1 = source |
| lock_o | output | 1 | Lock flag |
| mon_o | output | 1 | Monitor pin |
| cs_o | output | 1 | Current select to analog pump |

## Verification
The embedded assertions check the following on every cycle:
- the overlap always ends after its fixed length;
- up and down stay clear during the resync and power-save windows;
- the pump drives only when exactly one side is active;
- the lock flag changes only at the end of a comparison or on power-save entry;
- a large error always clears lock.

The streak arithmetic can only be shown by the bench's comparison sequence, with its chosen gaps and expected lock values. The same holds for error saturation, the polarity swap, the resync after power-save and the monitor selection.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
#(
  parameter int unsigned OVL_CYC = 1,
  parameter int unsigned ERR_SAT = 5,
  localparam int unsigned OW = cnt_w(OVL_CYC),
  localparam int unsigned EW = cnt_w(ERR_SAT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ps_ni,
  input  logic          ref_stb_i,
  input  logic          fb_stb_i,
  output logic          up_o,
  output logic          dn_o,
  output logic          done_o,
  output logic [EW-1:0] err_o
);
  logic          up_q, dn_q, resync_q, seen_r_q, seen_f_q;
  logic [OW-1:0] ovl_q;
  logic [EW-1:0] err_q;
  logic          busy, set_up, set_dn;

  assign busy   = up_q & dn_q;
  assign set_up = ref_stb_i & ~busy & ~resync_q & ps_ni;
  assign set_dn = fb_stb_i & ~busy & ~resync_q & ps_ni;
  assign done_o = (set_up | set_dn) & (up_q | set_up) & (dn_q | set_dn);

  always_comb begin
    if (!(up_q | dn_q))                 err_o = '0;
    else if (err_q >= EW'(ERR_SAT - 1)) err_o = EW'(ERR_SAT);
    else                                err_o = err_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0; dn_q <= 1'b0; ovl_q <= '0; err_q <= '0;
      resync_q <= 1'b1; seen_r_q <= 1'b0; seen_f_q <= 1'b0;
    end else if (!ps_ni) begin
      up_q <= 1'b0; dn_q <= 1'b0; ovl_q <= '0; err_q <= '0;
      resync_q <= 1'b1; seen_r_q <= 1'b0; seen_f_q <= 1'b0;
    end else if (resync_q) begin
      // discard first pair: phase relation unknown
      if ((seen_r_q | ref_stb_i) && (seen_f_q | fb_stb_i)) begin
        resync_q <= 1'b0; seen_r_q <= 1'b0; seen_f_q <= 1'b0;
      end else begin
        seen_r_q <= seen_r_q | ref_stb_i;
        seen_f_q <= seen_f_q | fb_stb_i;
      end
    end else if (busy) begin
      if (ovl_q == OW'(OVL_CYC - 1)) begin
        up_q <= 1'b0; dn_q <= 1'b0; ovl_q <= '0;
      end else begin
        ovl_q <= ovl_q + 1'b1;
      end
    end else begin
      up_q <= up_q | set_up;
      dn_q <= dn_q | set_dn;
      if (!(up_q | dn_q))               err_q <= '0;
      else if (err_q < EW'(ERR_SAT))    err_q <= err_q + 1'b1;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  a_r2_overlap_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && dn_q && ps_ni && ovl_q == OW'(OVL_CYC - 1)) |=> (!up_q && !dn_q));
  a_r9_resync_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_q |-> (!up_q && !dn_q));
  a_r5_err_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o <= EW'(ERR_SAT)));
  a_r1_up_from_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_q && !dn_q && ps_ni && !resync_q && ref_stb_i) |=> up_q);
endmodule

// File: rtl/lock_det.sv
module lock_det
  import pfd_lock_pkg::*;
#(
  parameter int unsigned ERR_SAT   = 5,
  parameter int unsigned UNLOCK_TH = 2,
  parameter int unsigned LOCK_TH   = 4,
  parameter int unsigned LOCK_CNT  = 3,
  localparam int unsigned EW = cnt_w(ERR_SAT),
  localparam int unsigned SW = cnt_w(LOCK_CNT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ps_ni,
  input  logic          done_i,
  input  logic [EW-1:0] err_i,
  output logic          lock_o
);
  logic [SW-1:0] streak_q, streak_n;
  logic          lock_q;

  always_comb begin
    if (err_i > EW'(LOCK_TH))                streak_n = '0;
    else if (streak_q >= SW'(LOCK_CNT))      streak_n = streak_q;
    else                                     streak_n = streak_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      streak_q <= '0; lock_q <= 1'b0;
    end else if (!ps_ni) begin
      streak_q <= '0; lock_q <= 1'b0;
    end else if (done_i) begin
      streak_q <= streak_n;
      if (err_i >= EW'(UNLOCK_TH))           lock_q <= 1'b0;
      else if (streak_n >= SW'(LOCK_CNT))    lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;

  a_r6_big_err_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ps_ni && err_i >= EW'(UNLOCK_TH)) |=> !lock_q);
  a_r7_lock_changes_on_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_q) |-> ($past(done_i) || !$past(ps_ni)));
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int unsigned OVL_CYC   = 1,
  parameter int unsigned ERR_SAT   = 5,
  parameter int unsigned UNLOCK_TH = 2,
  parameter int unsigned LOCK_TH   = 4,
  parameter int unsigned LOCK_CNT  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_stb_i,
  input  logic fb_stb_i,
  input  logic pol_i,
  input  logic mon_sel_i,
  input  logic hold_ni,
  input  logic ps_ni,
  input  logic cs_i,
  output logic ref_pulse_o,
  output logic fb_pulse_o,
  output logic cp_en_o,
  output logic cp_src_o,
  output logic lock_o,
  output logic mon_o,
  output logic cs_o
);
  localparam int unsigned EW = cnt_w(ERR_SAT);

  logic          up, dn, done, lock_q;
  logic [EW-1:0] err;

  pfd_core #(.OVL_CYC(OVL_CYC), .ERR_SAT(ERR_SAT)) u_core (
    .clk_i, .rst_ni, .ps_ni, .ref_stb_i, .fb_stb_i,
    .up_o(up), .dn_o(dn), .done_o(done), .err_o(err)
  );

  lock_det #(.ERR_SAT(ERR_SAT), .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH),
             .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i, .rst_ni, .ps_ni, .done_i(done), .err_i(err), .lock_o(lock_q)
  );

  assign ref_pulse_o = pol_i ? up : dn;
  assign fb_pulse_o  = pol_i ? dn : up;
  assign cp_en_o     = hold_ni & (up ^ dn);
  assign cp_src_o    = pol_i ? up : dn;
  assign lock_o      = ~ps_ni | lock_q;
  assign mon_o       = mon_sel_i ? (pol_i ? ref_stb_i : fb_stb_i) : lock_o;
  assign cs_o        = cs_i;

  a_r4_pump_single_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_en_o |-> (ref_pulse_o ^ fb_pulse_o));
  a_r8_ps_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ps_ni && !$past(ps_ni)) |-> (!ref_pulse_o && !fb_pulse_o && !cp_en_o));
endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // gap in edges, feedback-first flag, expected lock after the comparison
  localparam int V_K  [NV] = '{0, 1, 1, 3, 1, 6, 0, 4, 1, 2, 0};
  localparam int V_FB [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 1, 1};
  localparam int V_LK [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_stb = 0, fb_stb = 0, pol = 1, mon_sel = 0, hold_n = 1, ps_n = 1, cs = 0;
  logic ref_pulse, fb_pulse, cp_en, cp_src, lock, mon, cs_out;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_stb_i(ref_stb), .fb_stb_i(fb_stb),
    .pol_i(pol), .mon_sel_i(mon_sel), .hold_ni(hold_n), .ps_ni(ps_n), .cs_i(cs),
    .ref_pulse_o(ref_pulse), .fb_pulse_o(fb_pulse), .cp_en_o(cp_en),
    .cp_src_o(cp_src), .lock_o(lock), .mon_o(mon), .cs_o(cs_out)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cmp(input int fb_first, input int k);
    @(negedge clk);
    if (k == 0) begin ref_stb = 1; fb_stb = 1; end
    else if (fb_first != 0) fb_stb = 1;
    else ref_stb = 1;
    @(negedge clk); ref_stb = 0; fb_stb = 0;
    if (k > 0) begin
      repeat (k - 1) @(negedge clk);
      if (fb_first != 0) ref_stb = 1; else fb_stb = 1;
      @(negedge clk); ref_stb = 0; fb_stb = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ref_pulse, 0, "R12 ref_pulse"); chk(fb_pulse, 0, "R12 fb_pulse");
    chk(cp_en, 0, "R12 cp_en");         chk(lock, 0, "R12 lock");
    chk(mon, 0, "R12 mon");

    // R9: first pair after reset is discarded
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 0, "R9 ref strobe during resync");
    fb_stb = 1; @(negedge clk); fb_stb = 0;
    chk(fb_pulse, 0, "R9 fb strobe during resync");
    repeat (2) @(negedge clk);

    // R5 R6 R7: comparison sequence
    for (int i = 0; i < NV; i++) begin
      cmp(V_FB[i], V_K[i]);
      chk(lock, V_LK[i][0], $sformatf("R7/R6/R5 vector %0d", i));
    end

    // R1 R2 R3 R4: reference leads by 3 with pol=1
    @(negedge clk); ref_stb = 1;
    @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 1, "R1 up set"); chk(fb_pulse, 0, "R1 down idle");
    chk(cp_en, 1, "R4 pump drives"); chk(cp_src, 1, "R3 source when up pol=1");
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 1, "R1 repeat ref strobe keeps up"); chk(fb_pulse, 0, "R1 repeat ref no down");
    @(negedge clk); fb_stb = 1;
    @(negedge clk); fb_stb = 0; ref_stb = 1;
    chk(ref_pulse, 1, "R2 overlap up"); chk(fb_pulse, 1, "R2 overlap down");
    chk(cp_en, 0, "R4 pump off in overlap");
    @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 0, "R2 cleared and strobe dropped"); chk(fb_pulse, 0, "R2 down cleared");
    @(negedge clk);
    chk(ref_pulse, 0, "R2 dropped strobe stays dropped");
    fb_stb = 1; @(negedge clk); fb_stb = 0;
    chk(fb_pulse, 1, "R1 feedback leads sets down");
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    repeat (3) @(negedge clk);

    // R3 R4: reversed polarity and hold
    pol = 0;
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    chk(fb_pulse, 1, "R3 up on fb side pol=0"); chk(ref_pulse, 0, "R3 ref side idle pol=0");
    chk(cp_src, 0, "R3 sink when up pol=0");
    hold_n = 0; #1;
    chk(cp_en, 0, "R4 hold forces high-Z");
    hold_n = 1; #1;
    chk(cp_en, 1, "R4 pump resumes");
    @(negedge clk); fb_stb = 1; @(negedge clk); fb_stb = 0;
    repeat (3) @(negedge clk);
    pol = 1;

    // R11
    cs = 1; #1; chk(cs_out, 1, "R11 cs high");
    cs = 0; #1; chk(cs_out, 0, "R11 cs low");

    // R8: power save
    ps_n = 0; repeat (2) @(negedge clk);
    chk(lock, 1, "R8 lock forced in power save");
    chk(mon, 1, "R10 monitor shows lock");
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 0, "R8 strobe ignored"); chk(cp_en, 0, "R8 pump idle");
    ps_n = 1; @(negedge clk);
    chk(lock, 0, "R8 stored lock cleared");
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 0, "R9 first ref after wake");
    fb_stb = 1; @(negedge clk); fb_stb = 0;
    chk(fb_pulse, 0, "R9 first fb after wake"); chk(lock, 0, "R9 no lock update");
    ref_stb = 1; @(negedge clk); ref_stb = 0;
    chk(ref_pulse, 1, "R9 normal after resync");
    fb_stb = 1; @(negedge clk); fb_stb = 0;
    repeat (3) @(negedge clk);

    // R10: monitor select
    mon_sel = 1; pol = 1; ref_stb = 1; #1;
    chk(mon, 1, "R10 ref strobe on monitor pol=1");
    ref_stb = 0; fb_stb = 1; #1;
    chk(mon, 0, "R10 fb strobe hidden pol=1");
    pol = 0; #1;
    chk(mon, 1, "R10 fb strobe on monitor pol=0");
    fb_stb = 0; #1;
    chk(mon, 0, "R10 monitor low");
    mon_sel = 0; #1;
    chk(mon, lock, "R10 monitor back to lock");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule